// File: doc/BRIEF.md
# Serial Command and Mode-Register Write Receiver

This block is the serial slave front end of a data converter. A host reaches it over a 3-wire SPI-style link (chip select, serial clock, data in) and gets converter results back on a fourth wire. The receiver oversamples the link with its own system clock and brings the three link inputs through equal-length synchronizers, so the pins stay aligned with each other. It assembles incoming bytes MSB first and turns them into register writes. The first byte of each transaction is always reported as a command byte. When that byte carries the setup tag, it is also written to the setup register, and its two lowest bits choose where a second byte goes. The choices are the unipolar-mode register, the bipolar-mode register, or nowhere. The length of a transaction therefore depends on what the host sends.

While chip select is low, the block also shifts a 16-bit result word out on the data-out wire. The word is four zero bits followed by the 12-bit conversion result. The result is straight binary, or two's complement when the surrounding logic marks it as a signed result, such as a bipolar differential or a temperature reading. The link works with the serial clock idling low or idling high.

Top module: `spi_cmd_rx`

## Requirements
- R1: A falling chip select starts a transaction with the bit counter at zero. A rising chip select at any point discards a partially received byte, and the next transaction decodes correctly.
- R2: Data in is captured on each rising serial-clock edge while chip select is low, MSB first. When the first byte of a transaction completes, `cmdByte` takes its value and `cmdStrobe` pulses for one system clock.
- R3: A first byte whose bits 7:6 equal 01 is a setup byte. It is written to `setupReg`, and `setupWr` pulses in the same cycle as `cmdStrobe`. First bytes with other values of bits 7:6 leave `setupReg` unchanged.
- R4: If the setup byte's bits 1:0 equal 01, the next byte is written to `uniReg`, and `uniWr` pulses once.
- R5: If the setup byte's bits 1:0 equal 10, the next byte is written to `bipReg`, and `bipWr` pulses once.
- R6: If the setup byte's bits 1:0 equal 00 or 11, or the first byte is not a setup byte, the second byte writes nothing. Bytes after the second byte of a transaction write nothing.
- R7: `dout` presents a 16-bit word MSB first: four zeros, then the 12-bit result. The first bit is valid from the falling chip select. The word advances one bit on each falling serial-clock edge that follows at least one rising edge in the transaction.
- R8: When `resultTwos` is 1, the offset-binary `resultCode` is sent in two's complement, which means its MSB is inverted. When `resultTwos` is 0, it is sent unchanged.
- R9: Transactions decode and shift identically whether the serial clock idles low (mode 0) or high (mode 3). In mode 3, the falling edge that comes before the first rising edge does not advance `dout`.
- R10: If chip select rises in the same sampled cycle as the rising edge that would complete a byte, that byte is discarded and no strobe is issued.
- R11: After reset, `setupReg`, `uniReg`, `bipReg`, `cmdByte` and `dout` are zero. Each register keeps its value except in a cycle where its strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| resultCode | input | 12 | Conversion result, offset binary |
| resultTwos | input | 1 | Send the result in two's complement |
| dout | output | 1 | Serial result data to the host |
| cmdStrobe | output | 1 | One-cycle pulse when a first byte completes |
| cmdByte | output | 8 | Last first byte received |
| setupWr | output | 1 | One-cycle pulse when the setup register is written |
| uniWr | output | 1 | One-cycle pulse when the unipolar register is written |
| bipWr | output | 1 | One-cycle pulse when the bipolar register is written |
| setupReg | output | 8 | Setup register contents |
| uniReg | output | 8 | Unipolar-mode register contents |
| bipReg | output | 8 | Bipolar-mode register contents |

## Verification
Two events can land in one sampled system-clock cycle: the end of a transaction, signalled by chip select rising, and completion of a byte on the eighth rising serial-clock edge. Because both pins pass through synchronizers of the same depth, the bench raises chip select and the serial clock in the same time step, and the block sees both at once. The bench judges the outcome from the strobe pulse counters and the register contents: no strobe may appear, no register may change, and the next full transaction must decode normally.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [1:0] SETUP_TAG = 2'b01;

  typedef enum logic [1:0] {
    FOL_NONE = 2'b00,
    FOL_UNI  = 2'b01,
    FOL_BIP  = 2'b10,
    FOL_RSV  = 2'b11
  } followT;

  typedef struct packed {
    logic loadOut;
    logic shiftOut;
    logic shiftIn;
    logic wrCmd;
    logic wrSetup;
    logic wrUni;
    logic wrBip;
  } ctrlStrobeT;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else       chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sclkS,
  input  logic [1:0] nextTag,
  input  logic [1:0] nextSel,
  output ctrlStrobeT strb
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic csD, sclkD, seenRise;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0] byteIdx;
  followT follow;

  logic csLow, csFall, sRise, sFall, byteEnd;

  assign csLow   = ~csS;
  assign csFall  = csD & ~csS;
  assign sRise   = sclkS & ~sclkD;
  assign sFall   = ~sclkS & sclkD;
  assign byteEnd = csLow & sRise & (bitCnt == LAST_BIT);

  always_comb begin
    strb          = '0;
    strb.loadOut  = csFall;
    strb.shiftOut = csLow & sFall & seenRise & ~csFall;
    strb.shiftIn  = csLow & sRise;
    strb.wrCmd    = byteEnd & (byteIdx == 2'd0);
    strb.wrSetup  = byteEnd & (byteIdx == 2'd0) & (nextTag == SETUP_TAG);
    strb.wrUni    = byteEnd & (byteIdx == 2'd1) & (follow == FOL_UNI);
    strb.wrBip    = byteEnd & (byteIdx == 2'd1) & (follow == FOL_BIP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD <= 1'b1;
      sclkD <= 1'b0;
    end else begin
      csD <= csS;
      sclkD <= sclkS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      byteIdx  <= 2'd0;
      seenRise <= 1'b0;
      follow   <= FOL_NONE;
    end else if (!csLow) begin
      bitCnt   <= '0;
      byteIdx  <= 2'd0;
      seenRise <= 1'b0;
      follow   <= FOL_NONE;
    end else if (sRise) begin
      seenRise <= 1'b1;
      bitCnt   <= bitCnt + 1'b1;
      if (bitCnt == LAST_BIT) begin
        if (byteIdx != 2'd2) byteIdx <= byteIdx + 2'd1;
        if (byteIdx == 2'd0)
          follow <= (nextTag == SETUP_TAG) ? followT'(nextSel) : FOL_NONE;
      end
    end
  end
endmodule

// File: rtl/spi_rx_datapath.sv
module spi_rx_datapath
  import spi_rx_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic              dinS,
  input  logic [RES_W-1:0]  resultCode,
  input  logic              resultTwos,
  output logic [BYTE_W-1:0] nextByte,
  output logic              dout,
  output logic              cmdStrobe,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              setupWr,
  output logic              uniWr,
  output logic              bipWr,
  output logic [BYTE_W-1:0] setupReg,
  output logic [BYTE_W-1:0] uniReg,
  output logic [BYTE_W-1:0] bipReg
);
  localparam int PAD_W = WORD_W - RES_W;

  logic [BYTE_W-2:0] rxShift;
  logic [WORD_W-1:0] txShift;
  logic [RES_W-1:0]  fmtCode;

  assign nextByte = {rxShift, dinS};
  assign fmtCode  = resultTwos ? {~resultCode[RES_W-1], resultCode[RES_W-2:0]} : resultCode;
  assign dout     = txShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftIn) rxShift <= nextByte[BYTE_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txShift <= '0;
    else if (strb.loadOut) txShift <= {{PAD_W{1'b0}}, fmtCode};
    else if (strb.shiftOut) txShift <= {txShift[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdStrobe <= 1'b0;
      setupWr   <= 1'b0;
      uniWr     <= 1'b0;
      bipWr     <= 1'b0;
      cmdByte   <= '0;
      setupReg  <= '0;
      uniReg    <= '0;
      bipReg    <= '0;
    end else begin
      cmdStrobe <= strb.wrCmd;
      setupWr   <= strb.wrSetup;
      uniWr     <= strb.wrUni;
      bipWr     <= strb.wrBip;
      if (strb.wrCmd)   cmdByte  <= nextByte;
      if (strb.wrSetup) setupReg <= nextByte;
      if (strb.wrUni)   uniReg   <= nextByte;
      if (strb.wrBip)   bipReg   <= nextByte;
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_rx_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             din,
  input  logic [RES_W-1:0] resultCode,
  input  logic             resultTwos,
  output logic             dout,
  output logic             cmdStrobe,
  output logic [7:0]       cmdByte,
  output logic             setupWr,
  output logic             uniWr,
  output logic             bipWr,
  output logic [7:0]       setupReg,
  output logic [7:0]       uniReg,
  output logic [7:0]       bipReg
);
  logic [2:0] pinsS;
  logic [BYTE_W-1:0] nextByte;
  ctrlStrobeT strb;

  spi_rx_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rstN(rstN), .d({csN, sclk, din}), .q(pinsS)
  );

  spi_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csS(pinsS[2]), .sclkS(pinsS[1]),
    .nextTag(nextByte[7:6]), .nextSel(nextByte[1:0]), .strb(strb)
  );

  spi_rx_datapath #(.RES_W(RES_W), .WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .dinS(pinsS[0]),
    .resultCode(resultCode), .resultTwos(resultTwos),
    .nextByte(nextByte), .dout(dout), .cmdStrobe(cmdStrobe), .cmdByte(cmdByte),
    .setupWr(setupWr), .uniWr(uniWr), .bipWr(bipWr),
    .setupReg(setupReg), .uniReg(uniReg), .bipReg(bipReg)
  );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdStrobe,
  input logic [7:0] cmdByte,
  input logic       setupWr,
  input logic       uniWr,
  input logic       bipWr,
  input logic [7:0] setupReg,
  input logic [7:0] uniReg,
  input logic [7:0] bipReg
);
  a_r3_setup_with_cmd: assert property (@(posedge clk) disable iff (!rstN)
    setupWr |-> cmdStrobe);

  a_r3_setup_tag: assert property (@(posedge clk) disable iff (!rstN)
    setupWr |-> (setupReg[7:6] == 2'b01));

  a_r6_one_write_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({uniWr, bipWr, cmdStrobe}));

  a_r11_setup_hold: assert property (@(posedge clk) disable iff (!rstN)
    !setupWr |-> $stable(setupReg));

  a_r11_uni_hold: assert property (@(posedge clk) disable iff (!rstN)
    !uniWr |-> $stable(uniReg));

  a_r11_bip_hold: assert property (@(posedge clk) disable iff (!rstN)
    !bipWr |-> $stable(bipReg));

  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmdStrobe |-> $stable(cmdByte));
endmodule

bind spi_cmd_rx spi_cmd_rx_chk chk_i (.*);

// File: tb/spi_cmd_rx_tb_top.sv
module spi_cmd_rx_tb_top;
  localparam int HALF = 8;
  localparam int NVEC = 6;
  // vector: {first byte, second byte, mode3, twos, result code}
  localparam logic [29:0] VEC [NVEC] = '{
    {8'h41, 8'h3C, 1'b0, 1'b0, 12'hABC},
    {8'h42, 8'h96, 1'b1, 1'b1, 12'h800},
    {8'h40, 8'h77, 1'b0, 1'b1, 12'hFFF},
    {8'h13, 8'h55, 1'b1, 1'b0, 12'h001},
    {8'h43, 8'hEE, 1'b0, 1'b1, 12'h000},
    {8'h7E, 8'h21, 1'b1, 1'b0, 12'h5A5}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [11:0] resultCode = '0;
  logic resultTwos = 1'b0;
  logic dout, cmdStrobe, setupWr, uniWr, bipWr;
  logic [7:0] cmdByte, setupReg, uniReg, bipReg;

  int checkCnt = 0, failCnt = 0;
  int cmdCnt = 0, setCnt = 0, uniCnt = 0, bipCnt = 0;
  bit done = 1'b0;
  logic [7:0] expSet = '0, expUni = '0, expBip = '0, expCmd = '0;

  always #2 clk = ~clk;

  spi_cmd_rx dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .resultCode(resultCode), .resultTwos(resultTwos), .dout(dout),
    .cmdStrobe(cmdStrobe), .cmdByte(cmdByte), .setupWr(setupWr),
    .uniWr(uniWr), .bipWr(bipWr), .setupReg(setupReg), .uniReg(uniReg), .bipReg(bipReg)
  );

  always @(negedge clk) if (rstN) begin
    cmdCnt <= cmdCnt + int'(cmdStrobe);
    setCnt <= setCnt + int'(setupWr);
    uniCnt <= uniCnt + int'(uniWr);
    bipCnt <= bipCnt + int'(bipWr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] mosi, input int nbits, input bit mode3,
                      input bit abortLast, output logic [23:0] miso);
    miso = '0;
    sclk = mode3; csN = 1'b1; waitClk(HALF);
    csN = 1'b0; waitClk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      din = mosi[23-i];
      waitClk(HALF);
      miso[23-i] = dout;
      if (abortLast && i == nbits - 1) csN = 1'b1;
      sclk = 1'b1;
      waitClk(HALF);
    end
    sclk = mode3; waitClk(HALF);
    csN = 1'b1; waitClk(HALF);
  endtask

  // Reference model written from R2..R6
  task automatic model(input logic [7:0] b0, input logic [7:0] b1);
    expCmd = b0;
    if (b0[7:6] == 2'b01) begin
      expSet = b0;
      if (b0[1:0] == 2'b01) expUni = b1;
      if (b0[1:0] == 2'b10) expBip = b1;
    end
  endtask

  task automatic checkRegs(input string tag);
    chk(cmdByte == expCmd, {"R2 cmdByte ", tag}, cmdByte, expCmd);
    chk(setupReg == expSet, {"R3 setupReg ", tag}, setupReg, expSet);
    chk(uniReg == expUni, {"R4 uniReg ", tag}, uniReg, expUni);
    chk(bipReg == expBip, {"R5 bipReg ", tag}, bipReg, expBip);
  endtask

  initial begin
    logic [23:0] miso;
    logic [15:0] expWord;
    int c0, s0, u0, b0c;
    waitClk(5);
    // R11 reset values
    chk(dout == 1'b0, "R11 dout reset", dout, 0);
    chk(setupReg == 8'h00 && uniReg == 8'h00 && bipReg == 8'h00 && cmdByte == 8'h00,
        "R11 regs reset", {setupReg, uniReg, bipReg, cmdByte}, 0);
    rstN = 1'b1;
    waitClk(5);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] fb, sb;
      bit m3, tw;
      logic [11:0] code;
      {fb, sb, m3, tw, code} = VEC[v];
      resultCode = code; resultTwos = tw;
      c0 = cmdCnt; s0 = setCnt; u0 = uniCnt; b0c = bipCnt;
      xfer({fb, sb, 8'h00}, 16, m3, 1'b0, miso);
      model(fb, sb);
      expWord = {4'b0000, tw ? {~code[11], code[10:0]} : code};
      // R7 word layout, R8 format, R9 both clock idle levels
      chk(miso[23:8] == expWord, m3 ? "R7 R8 R9 dout word mode3" : "R7 R8 dout word mode0",
          miso[23:8], expWord);
      checkRegs($sformatf("vec%0d", v));
      chk(cmdCnt == c0 + 1, "R2 one cmdStrobe", cmdCnt - c0, 1);
      chk(setCnt - s0 == int'(fb[7:6] == 2'b01), "R3 setupWr count", setCnt - s0, int'(fb[7:6] == 2'b01));
      chk(uniCnt - u0 == int'(fb[7:6] == 2'b01 && fb[1:0] == 2'b01), "R4 R6 uniWr count",
          uniCnt - u0, int'(fb[7:6] == 2'b01 && fb[1:0] == 2'b01));
      chk(bipCnt - b0c == int'(fb[7:6] == 2'b01 && fb[1:0] == 2'b10), "R5 R6 bipWr count",
          bipCnt - b0c, int'(fb[7:6] == 2'b01 && fb[1:0] == 2'b10));
    end

    // R1: partial byte aborted, then a clean transaction
    c0 = cmdCnt;
    xfer(24'hFF0000, 5, 1'b0, 1'b0, miso);
    chk(cmdCnt == c0, "R1 partial byte no strobe", cmdCnt - c0, 0);
    checkRegs("R1 after abort");
    xfer(24'h425A00, 16, 1'b0, 1'b0, miso);
    model(8'h42, 8'h5A);
    checkRegs("R1 after restart");

    // R6: third byte ignored
    u0 = uniCnt;
    xfer(24'h41AA55, 24, 1'b1, 1'b0, miso);
    model(8'h41, 8'hAA);
    checkRegs("R6 third byte");
    chk(uniCnt == u0 + 1, "R6 single uniWr", uniCnt - u0, 1);

    // R10: CS rise collides with completing rising edge
    c0 = cmdCnt; s0 = setCnt;
    xfer(24'h410000, 8, 1'b0, 1'b1, miso);
    chk(cmdCnt == c0 && setCnt == s0, "R10 collision no strobe", cmdCnt - c0, 0);
    checkRegs("R10 collision");
    xfer(24'h42C300, 16, 1'b1, 1'b0, miso);
    model(8'h42, 8'hC3);
    checkRegs("R10 recovery");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule